// File: doc/BRIEF.md
# Ranged I/O Wait-State Controller

This block sits between a processor core and a dedicated peripheral I/O space of 2048 sixteen-bit locations. The space is cut into four equal ranges of 512 locations. Each range has its own programmable wait count, so slow and fast peripherals can share one bus without the fast ones paying the slow ones' penalty.

When the core issues a read or write, the block decodes the range from the top two address bits, takes that range's wait count, and drives the external read or write strobe for that count plus one cycle. Each wait state costs one instruction cycle. The core is stalled while the strobe is active. After the strobe drops, a one-cycle response returns the captured read data. Only one access is in flight at a time.

The four wait counts live in one configuration register that is written as a whole. A new value applies only to accesses accepted after the edge that stores it.

Top module: `ioWaitCtl`

## Requirements
- R1: After reset, every 3-bit wait field in `cfgWaits` reads 7 (`cfgWaits` = 12'hFFF), and `ioRd`, `ioWr`, `stall` and `rspValid` are all low.
- R2: The range of an access is `reqAddr[10:9]`. Range k uses the wait field `cfgWaits[3k+2:3k]`. Range 0 covers addresses 0x000–0x1FF, range 1 covers 0x200–0x3FF, range 2 covers 0x400–0x5FF and range 3 covers 0x600–0x7FF.
- R3: For an accepted access, the strobe starts in the cycle after the accepting edge. The strobe is `ioWr` when `reqWrite` = 1 and `ioRd` otherwise. It stays high for exactly the selected wait count + 1 consecutive cycles, so a wait count of 0 gives a single strobe cycle.
- R4: Read data on `ioDataIn` is sampled at the clock edge that ends the last strobe cycle. In the cycle right after the strobe, `rspValid` is high for one cycle and `rspRdata` shows that data. `rspRdata` then holds until the next read completes.
- R5: `stall` is high in exactly the cycles in which a strobe is active.
- R6: A request is accepted only when no strobe is active and `rspValid` is low. `reqValid` in any other cycle is ignored and starts no access.
- R7: Throughout a strobe, `ioAddr` equals the accepted address. During `ioWr`, `ioDataOut` equals the accepted write data. Both stay stable for the whole strobe.
- R8: `cfgWe` = 1 stores all four fields from `cfgWaitsIn` at the next edge. An access accepted on that same edge, or earlier, keeps the wait count it had when accepted.
- R9: `ioRd` and `ioWr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per period |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write enable for the wait-count register |
| cfgWaitsIn | input | 12 | New wait counts, 3 bits per range, range 0 in the low bits |
| cfgWaits | output | 12 | Current wait counts, same layout as `cfgWaitsIn` |
| reqValid | input | 1 | Core requests an I/O access |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 11 | I/O word address |
| reqWdata | input | 16 | Write data |
| stall | output | 1 | Core must hold while high |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read data of the last completed read |
| ioAddr | output | 11 | External I/O address |
| ioDataOut | output | 16 | External write data |
| ioDataIn | input | 16 | External read data |
| ioRd | output | 1 | External read strobe |
| ioWr | output | 1 | External write strobe |

## Verification
The bound checker watches four things on every cycle: that the strobes are mutually exclusive, that a strobe starts the cycle after an accept, that address and write data stay steady under a strobe, and that each strobe's length matches the wait field it was accepted with, followed by a response and then a quiet cycle. The following can only be shown by the bench's scenarios, using its per-clock reference model:
- that the correct range is decoded at the address boundaries;
- that read data is taken in the last strobe cycle rather than earlier, by a peripheral whose data changes every cycle;
- that requests held during a busy access are ignored;
- that a register write timed to coincide with, or fall inside, an access leaves that access's count unchanged.

// File: rtl/ioWaitPkg.sv
package ioWaitPkg;
  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadReq;   // latch address, data and direction of a new access
    logic capture;   // sample read data on this edge
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE   = 2'd2
  } ioState_t;
endpackage

// File: rtl/ioWaitDatapath.sv
module ioWaitDatapath
  import ioWaitPkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 16,
  parameter int RANGE_BITS = 2,
  parameter int WAIT_W     = 3,
  parameter int RESET_WAIT = 7,
  localparam int NUM_RANGES = 1 << RANGE_BITS,
  localparam int CFG_W      = NUM_RANGES * WAIT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWaitsIn,
  output logic [CFG_W-1:0]  cfgWaits,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] ioDataIn,
  output logic [WAIT_W-1:0] selWait,
  output logic              latWrite,
  output logic [ADDR_W-1:0] ioAddr,
  output logic [DATA_W-1:0] ioDataOut,
  output logic [DATA_W-1:0] rspRdata
);
  logic [WAIT_W-1:0]     waitField [NUM_RANGES];
  logic [RANGE_BITS-1:0] rangeSel;

  // One register per range; all written together.
  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_range
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      waitField[r] <= WAIT_W'(RESET_WAIT);
      else if (cfgWe) waitField[r] <= cfgWaitsIn[r*WAIT_W +: WAIT_W];
    end
    assign cfgWaits[r*WAIT_W +: WAIT_W] = waitField[r];
  end

  // Range decode from the top address bits of the incoming request.
  assign rangeSel = reqAddr[ADDR_W-1 -: RANGE_BITS];
  assign selWait  = waitField[rangeSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioAddr    <= '0;
      ioDataOut <= '0;
      latWrite  <= 1'b0;
    end else if (ctl.loadReq) begin
      ioAddr    <= reqAddr;
      ioDataOut <= reqWdata;
      latWrite  <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rspRdata <= '0;
    else if (ctl.capture) rspRdata <= ioDataIn;
  end
endmodule

// File: rtl/ioWaitCtrl.sv
module ioWaitCtrl
  import ioWaitPkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [WAIT_W-1:0] selWait,
  input  logic              latWrite,
  output ctlStrobes_t       ctl,
  output logic              stall,
  output logic              rspValid,
  output logic              ioRd,
  output logic              ioWr
);
  ioState_t          state, stateNext;
  logic [WAIT_W-1:0] waitLeft;
  logic              lastCycle;

  assign lastCycle = (state == ST_ACCESS) && (waitLeft == '0);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid)  stateNext = ST_ACCESS;
      ST_ACCESS: if (lastCycle) stateNext = ST_DONE;
      ST_DONE:                  stateNext = ST_IDLE;
      default:                  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitLeft <= '0;
    end else begin
      state <= stateNext;
      if (ctl.loadReq)             waitLeft <= selWait;
      else if (state == ST_ACCESS && !lastCycle) waitLeft <= waitLeft - 1'b1;
    end
  end

  always_comb begin
    ctl.loadReq = (state == ST_IDLE) && reqValid;
    ctl.capture = lastCycle && !latWrite;
  end

  assign stall    = (state == ST_ACCESS);
  assign rspValid = (state == ST_DONE);
  assign ioRd     = (state == ST_ACCESS) && !latWrite;
  assign ioWr     = (state == ST_ACCESS) &&  latWrite;
endmodule

// File: rtl/ioWaitCtl.sv
module ioWaitCtl
  import ioWaitPkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 16,
  parameter int RANGE_BITS = 2,
  parameter int WAIT_W     = 3,
  parameter int RESET_WAIT = 7,
  localparam int CFG_W     = (1 << RANGE_BITS) * WAIT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWaitsIn,
  output logic [CFG_W-1:0]  cfgWaits,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              stall,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] ioAddr,
  output logic [DATA_W-1:0] ioDataOut,
  input  logic [DATA_W-1:0] ioDataIn,
  output logic              ioRd,
  output logic              ioWr
);
  ctlStrobes_t       ctl;
  logic [WAIT_W-1:0] selWait;
  logic              latWrite;

  ioWaitCtrl #(.WAIT_W(WAIT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .selWait(selWait),
    .latWrite(latWrite), .ctl(ctl), .stall(stall), .rspValid(rspValid),
    .ioRd(ioRd), .ioWr(ioWr)
  );

  ioWaitDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RANGE_BITS(RANGE_BITS),
    .WAIT_W(WAIT_W), .RESET_WAIT(RESET_WAIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWaitsIn(cfgWaitsIn),
    .cfgWaits(cfgWaits), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ctl(ctl), .ioDataIn(ioDataIn), .selWait(selWait),
    .latWrite(latWrite), .ioAddr(ioAddr), .ioDataOut(ioDataOut),
    .rspRdata(rspRdata)
  );
endmodule

// File: rtl/ioWaitChk.sv
module ioWaitChk #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 16,
  parameter int RANGE_BITS = 2,
  parameter int WAIT_W     = 3,
  localparam int CFG_W     = (1 << RANGE_BITS) * WAIT_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [CFG_W-1:0]  cfgWaits,
  input logic              ioRd,
  input logic              ioWr,
  input logic              rspValid,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [DATA_W-1:0] ioDataOut
);
  logic              strobe, idle;
  logic [WAIT_W-1:0] expWait;
  logic [WAIT_W:0]   runLen;
  logic [RANGE_BITS-1:0] rng;

  assign strobe = ioRd | ioWr;
  assign idle   = !strobe && !rspValid;
  assign rng    = reqAddr[ADDR_W-1 -: RANGE_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expWait <= '0;
      runLen  <= '0;
    end else begin
      if (reqValid && idle) expWait <= cfgWaits[rng*WAIT_W +: WAIT_W];
      runLen <= strobe ? runLen + 1'b1 : '0;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd && ioWr)); // R9
  AST_STROBE_START: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && idle) |=> strobe); // R3
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> (runLen <= {1'b0, expWait})); // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe) |-> ($past(runLen) == {1'b0, expWait})); // R2
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe) |-> rspValid); // R4
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && $past(strobe)) |-> ($stable(ioAddr) && $stable(ioDataOut))); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !strobe); // R6
endmodule

bind ioWaitCtl ioWaitChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RANGE_BITS(RANGE_BITS), .WAIT_W(WAIT_W)
) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .cfgWaits(cfgWaits), .ioRd(ioRd), .ioWr(ioWr), .rspValid(rspValid),
  .ioAddr(ioAddr), .ioDataOut(ioDataOut)
);

// File: tb/test_ioWaitCtl.sv
`timescale 1ns/1ps
module test_ioWaitCtl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [11:0] cfgWaitsIn = '0;
  logic [11:0] cfgWaits;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [10:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        stall, rspValid, ioRd, ioWr;
  logic [15:0] rspRdata, ioDataOut;
  logic [15:0] ioDataIn = '0;
  logic [10:0] ioAddr;

  int nChecks = 0, nFails = 0;
  int cycleCnt = 0;

  always #4 clk = ~clk; // 125 MHz

  ioWaitCtl i_ioWaitCtl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWaitsIn(cfgWaitsIn),
    .cfgWaits(cfgWaits), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .stall(stall),
    .rspValid(rspValid), .rspRdata(rspRdata), .ioAddr(ioAddr),
    .ioDataOut(ioDataOut), .ioDataIn(ioDataIn), .ioRd(ioRd), .ioWr(ioWr)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Peripheral: read data changes every cycle so capture timing is visible.
  always @(negedge clk) begin
    cycleCnt++;
    ioDataIn = 16'h5A00 ^ 16'(cycleCnt);
  end

  // Behavioural reference model, compared every clock.
  int         mState = 0;   // 0 idle, 1 strobing, 2 response
  int         mLeft = 0;
  bit         mWr = 0;
  int         mAddr = 0, mWdata = 0, mRdata = 0;
  int         mCfg[4] = '{7, 7, 7, 7};

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mLeft = 0; mWr = 0; mAddr = 0; mWdata = 0; mRdata = 0;
      mCfg = '{7, 7, 7, 7};
    end else begin
      case (mState)
        0: if (reqValid) begin
             mState = 1; mWr = reqWrite; mAddr = reqAddr; mWdata = reqWdata;
             mLeft = mCfg[reqAddr / 512];
           end
        1: if (mLeft == 0) begin
             mState = 2;
             if (!mWr) mRdata = ioDataIn;
           end else mLeft--;
        default: mState = 0;
      endcase
      if (cfgWe) for (int k = 0; k < 4; k++) mCfg[k] = (cfgWaitsIn >> (3 * k)) & 7;
      #2;
      check(ioRd === (mState == 1 && !mWr), "R3 ioRd", ioRd, mState == 1 && !mWr);
      check(ioWr === (mState == 1 && mWr), "R3 R9 ioWr", ioWr, mState == 1 && mWr);
      check(stall === (mState == 1), "R5 stall", stall, mState == 1);
      check(rspValid === (mState == 2), "R4 rspValid", rspValid, mState == 2);
      check(rspRdata === 16'(mRdata), "R4 rspRdata", rspRdata, mRdata);
      for (int k = 0; k < 4; k++)
        check(cfgWaits[3*k +: 3] === 3'(mCfg[k]), "R8 cfgWaits", cfgWaits[3*k +: 3], mCfg[k]);
      if (mState == 1) begin
        check(ioAddr === 11'(mAddr), "R2 R6 R7 ioAddr", ioAddr, mAddr);
        if (mWr) check(ioDataOut === 16'(mWdata), "R7 ioDataOut", ioDataOut, mWdata);
      end
    end
  end

  task automatic cfgWrite(logic [11:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWaitsIn = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  // Issue one access from idle and measure the stall length.
  task automatic access(bit wr, logic [10:0] a, logic [15:0] d, int expWait);
    int n = 0;
    @(negedge clk); reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk); reqValid = 1'b0;
    while (stall && n < 20) begin n++; @(negedge clk); end
    check(n == expWait + 1, "R2 R3 strobe length", n, expWait + 1);
    check(rspValid === 1'b1, "R4 response after strobe", rspValid, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(cfgWaits === 12'hFFF, "R1 reset waits", cfgWaits, 12'hFFF);
    check({ioRd, ioWr, stall, rspValid} === 4'b0, "R1 reset outputs",
          {ioRd, ioWr, stall, rspValid}, 0);

    access(1'b0, 11'h005, 16'h0, 7);
    // range3=7, range2=3, range1=1, range0=0
    cfgWrite({3'd7, 3'd3, 3'd1, 3'd0});
    access(1'b0, 11'h000, 16'h0, 0);
    access(1'b1, 11'h1FF, 16'h1234, 0);
    access(1'b0, 11'h200, 16'h0, 1);
    access(1'b1, 11'h3FF, 16'hBEEF, 1);
    access(1'b0, 11'h400, 16'h0, 3);
    access(1'b1, 11'h5FF, 16'hC0DE, 3);
    access(1'b0, 11'h600, 16'h0, 7);
    access(1'b1, 11'h7FF, 16'hFACE, 7);

    // R6: request held high through busy cycles with changing fields.
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      reqValid = 1'b1; reqWrite = i[0]; reqAddr = 11'(i * 53); reqWdata = 16'(i * 777);
      @(negedge clk);
    end
    reqValid = 1'b0;
    repeat (12) @(negedge clk);

    // R8: register write inside an access leaves its count alone.
    begin
      int n = 0;
      reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 11'h700;
      @(negedge clk); reqValid = 1'b0; cfgWe = 1'b1; cfgWaitsIn = 12'h000;
      @(negedge clk); cfgWe = 1'b0; n = 1;
      while (stall && n < 20) begin n++; @(negedge clk); end
      check(n == 8, "R8 in-flight count kept", n, 8);
    end
    repeat (2) @(negedge clk);

    // R8: write on the accepting edge; access uses the old value (0).
    begin
      int n = 0;
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 11'h250; reqWdata = 16'h0F0F;
      cfgWe = 1'b1; cfgWaitsIn = {4{3'd5}};
      @(negedge clk); reqValid = 1'b0; cfgWe = 1'b0;
      while (stall && n < 20) begin n++; @(negedge clk); end
      check(n == 1, "R8 same-edge write uses old count", n, 1);
    end
    access(1'b0, 11'h250, 16'h0, 5);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule